// File: doc/BRIEF.md
# I2C Stuck-Bus Recovery Sequencer

This block frees an I2C bus whose data line is held low before a new transfer may begin. A controller pulses `start_i` ahead of each transfer. The sequencer then looks at the 4-bit state code reported by the bit engine. If that code does not read "lost arbitration" (0xC), the bus is usable and `done_o` pulses at once. If the code does read 0xC, the sequencer first turns off automatic transfer mode and turns on the receive channel. It then issues a manual read command. The bit engine answers that command with nine SCL pulses: eight data bits and a ninth clock on which it answers NACK. After the read, the sequencer issues a manual STOP command. After each of the two commands it waits for the engine's busy flag to fall.

Once the STOP has finished, the mode outputs return to their normal values and the state code is checked again. The read/STOP pair repeats for as long as the code stays at 0xC. An elapsed-cycle budget, `limit_i`, bounds both each busy wait and the whole retry loop. When the budget runs out while the bus is still stuck, `err_o` pulses and the sequencer goes back to idle.

The FSM has eight states: IDLE, CHECK, RD_ISSUE, RD_WAIT, SP_ISSUE, SP_WAIT, DONE and FAIL. Its transitions are:

- IDLE goes to CHECK on `start_i`.
- CHECK goes to DONE when the state code is not 0xC.
- CHECK goes to FAIL when the code is 0xC and the elapsed count has reached `limit_i`.
- CHECK goes to RD_ISSUE in every other case.
- RD_ISSUE goes to RD_WAIT.
- RD_WAIT goes to SP_ISSUE once busy is low or the wait count has reached `limit_i`.
- SP_ISSUE goes to SP_WAIT.
- SP_WAIT goes to CHECK under the same exit condition as RD_WAIT.
- DONE and FAIL both go to IDLE.

Top module: `i2c_bus_unstick`

## Requirements
- R1: After reset, `auto_mode_o`=1, `rx_chan_o`=0, and `cmd_valid_o`, `done_o` and `err_o` are all 0.
- R2: If the state code is not 0xC at the CHECK following `start_i`, `done_o` pulses without any command being issued. This holds even when `limit_i` is 0.
- R3: If the state code is 0xC, the first command is a manual read: `cmd_valid_o`=1 with `cmd_word_o`=8'h10 (bit 4 set). This command asks the engine for nine SCL pulses, eight data bits plus a NACK.
- R4: Each read is followed, after its busy wait, by a manual STOP: `cmd_word_o`=8'h04 (bit 2 set). A STOP is never issued without a read before it.
- R5: While a recovery command is issued or awaited, `auto_mode_o`=0 and `rx_chan_o`=1. In CHECK, DONE, FAIL and IDLE both outputs are back at 1 and 0.
- R6: Read/STOP pairs repeat for as long as the state code stays at 0xC. `done_o` pulses at the first CHECK that finds another code.
- R7: A busy wait ends after at most `limit_i`+1 cycles even if busy never falls, and the sequence then continues.
- R8: Elapsed cycles are counted from the cycle after `start_i`. If the count is at least `limit_i` at a CHECK and the code is still 0xC, `err_o` pulses and no further command follows. With `limit_i`=0 this happens before any command.
- R9: `done_o` and `err_o` are one-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a bus check/recovery (taken in IDLE) |
| mstate_i | input | 4 | Master state code from the bit engine (0xC = lost arbitration) |
| busy_i | input | 1 | Master-busy flag from the bit engine |
| limit_i | input | TMR_W | Cycle budget for each busy wait and for the whole retry loop |
| auto_mode_o | output | 1 | Automatic transfer mode enable (0 during recovery) |
| rx_chan_o | output | 1 | Receive channel enable (1 during recovery) |
| cmd_valid_o | output | 1 | Manual command strobe, one cycle |
| cmd_word_o | output | 8 | Manual command word: bit 4 = read, bit 2 = STOP |
| done_o | output | 1 | Bus found free, one-cycle pulse |
| err_o | output | 1 | Budget expired with bus still stuck, one-cycle pulse |

## Verification
The checker watches several properties on every cycle:

- Every command strobe carries one of the two legal words.
- Commands only occur with automatic mode off and the receive channel on.
- Every `done_o` comes with the mode outputs restored, and follows a sampled state code other than 0xC.
- The completion pulses are single and exclusive.

Some behaviours only the bench scenarios can show. These are the number of read/STOP pairs before completion, and the way the retry count follows from the busy length and the budget. The bench also covers a busy flag that never falls, and the priority of a free bus over an expired budget.

// File: rtl/i2c_bus_unstick_pkg.sv
package i2c_bus_unstick_pkg;

    localparam int          CMD_W      = 8;
    localparam int          RD_BIT     = 4;
    localparam int          SP_BIT     = 2;
    localparam logic [3:0]  MST_LOST   = 4'hC;
    localparam logic [CMD_W-1:0] CMD_RD = CMD_W'(1) << RD_BIT;
    localparam logic [CMD_W-1:0] CMD_SP = CMD_W'(1) << SP_BIT;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_RD_ISSUE,
        ST_RD_WAIT,
        ST_SP_ISSUE,
        ST_SP_WAIT,
        ST_DONE,
        ST_FAIL
    } unstick_state_t;

endpackage

// File: rtl/unstick_meter.sv
module unstick_meter #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic [TMR_W-1:0] limit_i,
    output logic             reach_o
);
    localparam logic [TMR_W-1:0] CNT_MAX = {TMR_W{1'b1}};

    logic [TMR_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (en_i && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign reach_o = (cnt_q >= limit_i);
endmodule

// File: rtl/i2c_bus_unstick.sv
module i2c_bus_unstick
    import i2c_bus_unstick_pkg::*;
#(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [3:0]       mstate_i,
    input  logic             busy_i,
    input  logic [TMR_W-1:0] limit_i,
    output logic             auto_mode_o,
    output logic             rx_chan_o,
    output logic             cmd_valid_o,
    output logic [CMD_W-1:0] cmd_word_o,
    output logic             done_o,
    output logic             err_o
);

    unstick_state_t state_q, state_d;
    logic           ovr_reach, wt_reach;
    logic           in_wait, in_recov, bus_lost, wait_exit;

    assign bus_lost  = (mstate_i == MST_LOST);
    assign in_wait   = (state_q == ST_RD_WAIT) || (state_q == ST_SP_WAIT);
    assign wait_exit = !busy_i || wt_reach;

    // elapsed cycles since start, for the retry loop budget
    unstick_meter #(.TMR_W(TMR_W)) u_ovr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (state_q == ST_IDLE),
        .en_i    (1'b1),
        .limit_i (limit_i),
        .reach_o (ovr_reach)
    );

    // cycles spent in the current busy wait
    unstick_meter #(.TMR_W(TMR_W)) u_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (!in_wait),
        .en_i    (in_wait),
        .limit_i (limit_i),
        .reach_o (wt_reach)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start_i) state_d = ST_CHECK;
            ST_CHECK: begin
                if (!bus_lost)      state_d = ST_DONE;
                else if (ovr_reach) state_d = ST_FAIL;
                else                state_d = ST_RD_ISSUE;
            end
            ST_RD_ISSUE: state_d = ST_RD_WAIT;
            ST_RD_WAIT:  if (wait_exit) state_d = ST_SP_ISSUE;
            ST_SP_ISSUE: state_d = ST_SP_WAIT;
            ST_SP_WAIT:  if (wait_exit) state_d = ST_CHECK;
            ST_DONE:     state_d = ST_IDLE;
            ST_FAIL:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    assign in_recov = (state_q == ST_RD_ISSUE) || (state_q == ST_SP_ISSUE) || in_wait;

    always_comb begin
        auto_mode_o = !in_recov;
        rx_chan_o   = in_recov;
        cmd_valid_o = 1'b0;
        cmd_word_o  = '0;
        done_o      = 1'b0;
        err_o       = 1'b0;
        unique case (state_q)
            ST_RD_ISSUE: begin cmd_valid_o = 1'b1; cmd_word_o = CMD_RD; end
            ST_SP_ISSUE: begin cmd_valid_o = 1'b1; cmd_word_o = CMD_SP; end
            ST_DONE:     done_o = 1'b1;
            ST_FAIL:     err_o  = 1'b1;
            default: ;
        endcase
    end
endmodule

module i2c_bus_unstick_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] mstate_i,
    input logic       auto_mode_o,
    input logic       rx_chan_o,
    input logic       cmd_valid_o,
    input logic [7:0] cmd_word_o,
    input logic       done_o,
    input logic       err_o
);
    // R3
    cmd_word_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> (cmd_word_o == 8'h10 || cmd_word_o == 8'h04));

    // R4
    stop_not_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_word_o == 8'h04) |-> !$past(cmd_valid_o));

    // R5
    cmd_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> (!auto_mode_o && rx_chan_o));

    // R5
    done_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || err_o) |-> (auto_mode_o && !rx_chan_o));

    // R2
    done_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(mstate_i) != 4'hC));

    // R9
    done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || err_o) |=> !(done_o || err_o));
endmodule

bind i2c_bus_unstick i2c_bus_unstick_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mstate_i    (mstate_i),
    .auto_mode_o (auto_mode_o),
    .rx_chan_o   (rx_chan_o),
    .cmd_valid_o (cmd_valid_o),
    .cmd_word_o  (cmd_word_o),
    .done_o      (done_o),
    .err_o       (err_o)
);

// File: tb/i2c_bus_unstick_test.sv
module i2c_bus_unstick_test;
    localparam int TMR_W = 16;
    localparam int EV_DONE = 256;
    localparam int EV_ERR  = 512;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [3:0]       mstate_i;
    logic             busy_i;
    logic [TMR_W-1:0] limit_i = '0;
    logic             auto_mode_o, rx_chan_o, cmd_valid_o, done_o, err_o;
    logic [7:0]       cmd_word_o;

    int compared = 0;
    int mismatched = 0;

    // bus model configuration
    logic       cfg_lost = 1'b0;
    int         cfg_clear = 0;
    logic [3:0] cfg_other = 4'h0;
    int         cfg_blen = 0;
    logic       cfg_stuck = 1'b0;
    logic       model_clr = 1'b0;
    int         stops = 0;
    int         bcnt = 0;
    logic       busy_m = 1'b0;

    int    exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    i2c_bus_unstick #(.TMR_W(TMR_W)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mstate_i(mstate_i),
        .busy_i(busy_i), .limit_i(limit_i), .auto_mode_o(auto_mode_o),
        .rx_chan_o(rx_chan_o), .cmd_valid_o(cmd_valid_o), .cmd_word_o(cmd_word_o),
        .done_o(done_o), .err_o(err_o)
    );

    assign mstate_i = (cfg_lost && (cfg_clear == 0 || stops < cfg_clear)) ? 4'hC : cfg_other;
    assign busy_i   = busy_m | cfg_stuck;

    always @(posedge clk) begin
        if (model_clr) begin
            stops  <= 0;
            busy_m <= 1'b0;
            bcnt   <= 0;
        end else if (cmd_valid_o) begin
            if (cmd_word_o == 8'h04) stops <= stops + 1;
            busy_m <= (cfg_blen > 0);
            bcnt   <= cfg_blen;
        end else if (busy_m) begin
            if (bcnt == 1) busy_m <= 1'b0;
            bcnt <= bcnt - 1;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // monitor: pops expected events as the design produces them
    always @(negedge clk) begin
        if (rst_n && (cmd_valid_o || done_o || err_o)) begin
            int act;
            act = (cmd_valid_o ? int'(cmd_word_o) : 0) | (done_o ? EV_DONE : 0) | (err_o ? EV_ERR : 0);
            if (exp_q.size() == 0) begin
                check(1'b0, "unexpected event", act, 0);
            end else begin
                int    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(act == e, t, act, e);
            end
            if (cmd_valid_o)
                check(!auto_mode_o && rx_chan_o, "R5 mode during command",
                      {auto_mode_o, rx_chan_o}, 2'b01);
            else
                check(auto_mode_o && !rx_chan_o, "R5 mode restored at end",
                      {auto_mode_o, rx_chan_o}, 2'b10);
        end
    end

    task automatic push(input int e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    task automatic run(input logic lost, input int clr_after, input logic [3:0] other,
                       input int blen, input logic stuck, input int lim);
        int guard;
        @(negedge clk);
        cfg_lost = lost; cfg_clear = clr_after; cfg_other = other;
        cfg_blen = blen; cfg_stuck = stuck; limit_i = TMR_W'(lim);
        model_clr = 1'b1;
        @(negedge clk);
        model_clr = 1'b0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        guard = 0;
        while (exp_q.size() != 0 && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        check(exp_q.size() == 0, "scenario completion", exp_q.size(), 0);
        exp_q.delete();
        tag_q.delete();
        repeat (3) @(negedge clk);
        check(auto_mode_o && !rx_chan_o && !cmd_valid_o, "R5 idle after scenario",
              {auto_mode_o, rx_chan_o, cmd_valid_o}, 3'b100);
    endtask

    // iterations before the budget check fails when the bus never frees
    function automatic int iters(input int blen, input logic stuck, input int lim);
        int w, t, n;
        w = ((stuck || blen > lim) ? lim : blen) + 1;
        t = 3 + 2 * w;
        n = 0;
        while (n * t < lim) n++;
        return n;
    endfunction

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1
        check(auto_mode_o && !rx_chan_o && !cmd_valid_o && !done_o && !err_o,
              "R1 reset state", {auto_mode_o, rx_chan_o, cmd_valid_o, done_o, err_o}, 5'b10000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: free bus (wait state code) -> done, no commands
        push(EV_DONE, "R2 free bus done");
        run(1'b0, 0, 4'hD, 2, 1'b0, 100);

        // R3 R4 R6: clears after one pair
        push(8'h10, "R3 read command"); push(8'h04, "R4 stop after read");
        push(EV_DONE, "R6 done once freed");
        run(1'b1, 1, 4'h0, 2, 1'b0, 100);

        // R6: three pairs, busy never rising
        for (int i = 0; i < 3; i++) begin
            push(8'h10, "R6 repeated read"); push(8'h04, "R6 repeated stop");
        end
        push(EV_DONE, "R6 done after three pairs");
        run(1'b1, 3, 4'h1, 0, 1'b0, 200);

        // R8: never frees, budget expires
        n = iters(2, 1'b0, 40);
        for (int i = 0; i < n; i++) begin
            push(8'h10, "R8 read before expiry"); push(8'h04, "R8 stop before expiry");
        end
        push(EV_ERR, "R8 error on expiry");
        run(1'b1, 0, 4'h0, 2, 1'b0, 40);

        // R7: busy stuck high, waits bounded
        n = iters(0, 1'b1, 6);
        for (int i = 0; i < n; i++) begin
            push(8'h10, "R7 read with stuck busy"); push(8'h04, "R7 stop after bounded wait");
        end
        push(EV_ERR, "R7 error after bounded waits");
        run(1'b1, 0, 4'h0, 0, 1'b1, 6);

        // R8: zero budget, stuck bus -> error without commands
        push(EV_ERR, "R8 zero budget error");
        run(1'b1, 0, 4'h0, 2, 1'b0, 0);

        // R2: zero budget, free bus -> done takes priority
        push(EV_DONE, "R2 free bus beats zero budget");
        run(1'b0, 0, 4'h0, 2, 1'b0, 0);

        // R9: long busy, clears after two pairs
        for (int i = 0; i < 2; i++) begin
            push(8'h10, "R9 read"); push(8'h04, "R9 stop");
        end
        push(EV_DONE, "R9 single done");
        run(1'b1, 2, 4'hE, 9, 1'b0, 300);
        check(!done_o && !err_o, "R9 no lingering pulse", {done_o, err_o}, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL watchdog: actual expired expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule